// File: doc/BRIEF.md
# Zero-Padding Complex Window Pre-Processor

This block prepares real-valued sample records for a power-of-two FFT core. Each trigger opens a record of real samples. The block stores the record in a local buffer. When the record is complete, it streams the record out as complex points. Each stored sample is multiplied by a complex coefficient taken from a loadable table, and the product is rounded and saturated back to the sample width.

The configured number of valid samples does not have to be a power of two. When it is not, the block appends zero-valued complex points until the frame reaches the smallest power of two that is not below the count. The coefficient table is indexed by sample position and only needs as many entries as there are valid samples. A complex coefficient lets a real taper and a phase correction be merged into one multiplication.

The output uses a valid/ready handshake and carries flags for the first and last point of each frame. A trigger that arrives while a frame is still being captured or sent is refused: it raises a one-cycle overflow pulse and is dropped.

Top module: `cwin_zpad_window`

## Requirements
- R1: The output frame length is the smallest power of two that is not below `cfg_count` (for counts from 1 to 2^LOG2_MAX, default 4096). A count that is already a power of two gives a frame of exactly that length, and a count of 1352 gives 2048 points. `cfg_count` is sampled when the frame starts.
- R2: For output index i below the count, each component equals sat(floor((x_i * c_i + 2^14) / 2^15)). Here x_i is the 12-bit signed sample and c_i is the matching 16-bit signed Q1.15 coefficient component. sat limits the result to the range -2048..2047, so sample -2048 with coefficient -32768 gives 2047.
- R3: Output indices from the count up to the frame length are zero in both the real and the imaginary part.
- R4: `out_first` is 1 only on index 0 of a frame, and `out_last` is 1 only on index length-1. After the last point is accepted, `out_valid` falls.
- R5: A write on the coefficient port stores real part `coef_re` and imaginary part `coef_im` at table position `coef_addr`. Sample i of every later frame uses position i.
- R6: Coefficient writes made while a record is being captured or emitted are ignored. Later frames still see the old table entry.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output point and both flags stay unchanged.
- R8: A start marker (`in_valid` and `in_sof` both 1) that arrives while capturing or emitting produces a one-cycle `overflow` pulse on the next cycle. It is not stored, and the frame in progress is unchanged.
- R9: After reset, `out_valid` and `overflow` are 0.
- R10: Outside a frame, samples without a start marker are ignored. A frame begins only with a start marker seen while idle, and only cycles with `in_valid` at 1 carry samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_count | input | LOG2_MAX+1 | Valid samples per record |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Marks the first sample of a record |
| in_sample | input | DW | Signed real sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | LOG2_MAX | Coefficient table position |
| coef_re | input | CW | Coefficient real part, Q1.15 |
| coef_im | input | CW | Coefficient imaginary part, Q1.15 |
| out_valid | output | 1 | Output point present |
| out_ready | input | 1 | Downstream accepts the point |
| out_re | output | DW | Real part of the output point |
| out_im | output | DW | Imaginary part of the output point |
| out_first | output | 1 | First point of the frame |
| out_last | output | 1 | Last point of the frame |
| overflow | output | 1 | Refused-trigger pulse |

## Verification
Assertions check four things on every cycle:
- the output holds steady under backpressure;
- the first flag falls on beat zero and the last flag on beat length-1;
- `out_valid` falls after the last point is accepted;
- every overflow pulse follows a start marker.

Only the bench scenarios can show the rest:
- the arithmetic: rounding, saturation at both extremes, and zero fill;
- that a coefficient written while busy leaves later frames unchanged;
- that a refused trigger leaves the frame in flight unchanged.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_EMIT = 2'd2
   } cw_state_e;
endpackage

// File: rtl/cwin_len_calc.sv
module cwin_len_calc #(
   parameter int LOG2_MAX = 12
) (
   input  logic [LOG2_MAX:0] count_raw,
   output logic [LOG2_MAX:0] count_eff,
   output logic [LOG2_MAX:0] frame_len
);
   localparam int LW = LOG2_MAX + 1;
   localparam logic [LW-1:0] MAXLEN = LW'(1) << LOG2_MAX;

   always_comb begin
      count_eff = count_raw;
      if (count_raw == '0)
         count_eff = LW'(1);
      else if (count_raw > MAXLEN)
         count_eff = MAXLEN;
      frame_len = MAXLEN;
      // descending scan leaves the smallest power that covers the count
      for (int k = LOG2_MAX; k >= 0; k--) begin
         if ((LW'(1) << k) >= count_eff)
            frame_len = LW'(1) << k;
      end
   end
endmodule

// File: rtl/cwin_ram.sv
module cwin_ram #(
   parameter int WIDTH = 12,
   parameter int AW    = 12
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cwin_cmul.sv
module cwin_cmul #(
   parameter int DW    = 12,
   parameter int CW    = 16,
   parameter int ROUND = 1
) (
   input  logic signed [DW-1:0] sample,
   input  logic signed [CW-1:0] c_re,
   input  logic signed [CW-1:0] c_im,
   output logic signed [DW-1:0] p_re,
   output logic signed [DW-1:0] p_im
);
   localparam int PW = DW + CW;
   localparam int SH = CW - 1;
   localparam int SW = PW - SH;
   localparam logic signed [SW-1:0] HI = SW'((1 << (DW - 1)) - 1);
   localparam logic signed [SW-1:0] LO = -SW'(1 << (DW - 1));

   logic signed [CW-1:0] coef [2];
   assign coef[0] = c_re;
   assign coef[1] = c_im;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic signed [PW-1:0] prod;
      logic signed [PW-1:0] biased;
      logic signed [SW-1:0] scaled;
      logic signed [DW-1:0] sat;

      assign prod = sample * coef[g];

      if (ROUND != 0) begin : g_rnd
         assign biased = prod + (PW'(1) <<< (SH - 1));
      end else begin : g_trn
         assign biased = prod;
      end

      assign scaled = biased[PW-1:SH];

      always_comb begin
         if (scaled > HI)
            sat = HI[DW-1:0];
         else if (scaled < LO)
            sat = LO[DW-1:0];
         else
            sat = scaled[DW-1:0];
      end
   end

   assign p_re = g_lane[0].sat;
   assign p_im = g_lane[1].sat;
endmodule

// File: rtl/cwin_zpad_window.sv
module cwin_zpad_window
   import cwin_pkg::*;
#(
   parameter int LOG2_MAX = 12,
   parameter int DW       = 12,
   parameter int CW       = 16,
   parameter int ROUND    = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LOG2_MAX:0]    cfg_count,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic signed [DW-1:0] in_sample,
   input  logic                 coef_we,
   input  logic [LOG2_MAX-1:0]  coef_addr,
   input  logic signed [CW-1:0] coef_re,
   input  logic signed [CW-1:0] coef_im,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im,
   output logic                 out_first,
   output logic                 out_last,
   output logic                 overflow
);
   localparam int LW = LOG2_MAX + 1;

   initial begin
      assert (LOG2_MAX >= 1 && LOG2_MAX <= 16) else $error("LOG2_MAX out of range");
      assert (DW >= 2 && CW >= 2) else $error("data or coefficient width too small");
   end

   cw_state_e         state;
   logic [LW-1:0]     cnt_eff, len_eff, cnt_q, len_q, rd_idx;
   logic [LOG2_MAX-1:0] wr_idx;
   logic              start_hit, samp_we, coef_wr, adv;
   logic [LOG2_MAX-1:0] samp_waddr;
   logic signed [DW-1:0] samp_rd, p_re, p_im;
   logic [2*CW-1:0]   coef_rd;

   cwin_len_calc #(.LOG2_MAX(LOG2_MAX)) i_len (
      .count_raw(cfg_count), .count_eff(cnt_eff), .frame_len(len_eff)
   );

   assign start_hit  = in_valid && in_sof;
   assign samp_we    = (state == ST_IDLE && start_hit) ||
                       (state == ST_FILL && in_valid && !in_sof);
   assign samp_waddr = (state == ST_IDLE) ? '0 : wr_idx;
   assign coef_wr    = coef_we && (state == ST_IDLE);

   cwin_ram #(.WIDTH(DW), .AW(LOG2_MAX)) i_samp_ram (
      .clk(clk), .we(samp_we), .waddr(samp_waddr), .wdata(in_sample),
      .raddr(rd_idx[LOG2_MAX-1:0]), .rdata(samp_rd)
   );

   cwin_ram #(.WIDTH(2*CW), .AW(LOG2_MAX)) i_coef_ram (
      .clk(clk), .we(coef_wr), .waddr(coef_addr), .wdata({coef_re, coef_im}),
      .raddr(rd_idx[LOG2_MAX-1:0]), .rdata(coef_rd)
   );

   cwin_cmul #(.DW(DW), .CW(CW), .ROUND(ROUND)) i_cmul (
      .sample(samp_rd), .c_re(coef_rd[2*CW-1:CW]), .c_im(coef_rd[CW-1:0]),
      .p_re(p_re), .p_im(p_im)
   );

   assign adv = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt_q     <= '0;
         len_q     <= '0;
         wr_idx    <= '0;
         rd_idx    <= '0;
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         overflow  <= 1'b0;
      end else begin
         overflow <= start_hit && (state != ST_IDLE);
         case (state)
            ST_IDLE: begin
               if (start_hit) begin
                  cnt_q  <= cnt_eff;
                  len_q  <= len_eff;
                  wr_idx <= LOG2_MAX'(1);
                  rd_idx <= '0;
                  state  <= (cnt_eff == LW'(1)) ? ST_EMIT : ST_FILL;
               end
            end
            ST_FILL: begin
               if (in_valid && !in_sof) begin
                  wr_idx <= wr_idx + LOG2_MAX'(1);
                  if ({1'b0, wr_idx} == cnt_q - LW'(1))
                     state <= ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (adv) begin
                  if (rd_idx < len_q) begin
                     out_valid <= 1'b1;
                     out_re    <= (rd_idx < cnt_q) ? p_re : '0;
                     out_im    <= (rd_idx < cnt_q) ? p_im : '0;
                     out_first <= (rd_idx == '0);
                     out_last  <= (rd_idx == len_q - LW'(1));
                     rd_idx    <= rd_idx + LW'(1);
                  end else begin
                     out_valid <= 1'b0;
                     out_first <= 1'b0;
                     out_last  <= 1'b0;
                     state     <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // beat counter kept only for the frame-length checks below
   logic [LW-1:0] beat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_cnt <= '0;
      else if (out_valid && out_ready)
         beat_cnt <= out_last ? '0 : beat_cnt + LW'(1);
   end

   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)
                                  && $stable(out_first) && $stable(out_last));

   a_r1_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |-> beat_cnt + LW'(1) == len_q);

   a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_first |-> beat_cnt == '0);

   a_r4_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid);

   a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> $past(in_valid && in_sof));
endmodule

// File: tb/test_cwin_zpad_window.sv
module test_cwin_zpad_window;
   localparam int CLK_PERIOD = 10;
   localparam int LG = 12;
   localparam int NMAX = 1 << LG;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LG:0] cfg_count = '0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic signed [11:0] in_sample = '0;
   logic coef_we = 1'b0;
   logic [LG-1:0] coef_addr = '0;
   logic signed [15:0] coef_re = '0, coef_im = '0;
   logic out_valid, out_ready, out_first, out_last, overflow;
   logic signed [11:0] out_re, out_im;

   always #(CLK_PERIOD/2) clk = ~clk;

   cwin_zpad_window i_cwin_zpad_window (
      .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count),
      .in_valid(in_valid), .in_sof(in_sof), .in_sample(in_sample),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_re(coef_re), .coef_im(coef_im),
      .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
      .out_first(out_first), .out_last(out_last), .overflow(overflow)
   );

   typedef struct {
      int re; int im; bit first; bit last; bit pad;
   } exp_t;

   exp_t sbq[$];
   int checks = 0, errors = 0;
   int cre[NMAX], cim[NMAX], smp[NMAX];
   int ovf_seen = 0;
   int ready_mode = 0;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int scl(int x, int c);
      longint p;
      p = (longint'(x) * longint'(c) + 64'sd16384) >>> 15;
      if (p > 2047) p = 2047;
      if (p < -2048) p = -2048;
      return int'(p);
   endfunction

   // ready driver
   initial begin
      int rc = 0;
      out_ready = 1'b0;
      forever begin
         @(posedge clk); #1;
         rc++;
         case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ((rc * 7) % 5) != 0;
            default: out_ready = 1'b0;
         endcase
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (overflow) ovf_seen++;
         if (out_valid && out_ready) begin
            if (sbq.size() == 0) begin
               check("R1", "unexpected extra point", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               check(e.pad ? "R3" : "R2", "real part", int'(out_re), e.re);
               check(e.pad ? "R3" : "R2", "imag part", int'(out_im), e.im);
               check("R4", "first flag", int'(out_first), int'(e.first));
               check("R4", "last flag", int'(out_last), int'(e.last));
            end
         end
      end
   end

   task automatic write_coef(int i, int re, int im);
      @(posedge clk); #1;
      coef_we = 1'b1; coef_addr = LG'(i); coef_re = 16'(re); coef_im = 16'(im);
      cre[i] = re; cim[i] = im;
      @(posedge clk); #1;
      coef_we = 1'b0;
   endtask

   task automatic load_coefs(int n, int seed);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         cre[i] = ((i * 2654 + seed * 977) % 65536) - 32768;
         cim[i] = ((i * 40503 + seed * 313 + 12345) % 65536) - 32768;
         coef_we = 1'b1; coef_addr = LG'(i);
         coef_re = 16'(cre[i]); coef_im = 16'(cim[i]);
      end
      @(posedge clk); #1;
      coef_we = 1'b0;
   endtask

   task automatic fill_samples(int n, int seed);
      for (int i = 0; i < n; i++) smp[i] = ((i * 37 + seed * 11 + 5) % 4096) - 2048;
   endtask

   // push expected frame, then drive the record; glitch_at inserts a stray start marker,
   // poke_at issues a coefficient write during capture
   task automatic run_frame(int n, int glitch_at, int poke_at);
      int len = 1;
      while (len < n) len = len * 2;
      for (int i = 0; i < len; i++) begin
         exp_t e;
         e.pad   = (i >= n);
         e.re    = e.pad ? 0 : scl(smp[i], cre[i]);
         e.im    = e.pad ? 0 : scl(smp[i], cim[i]);
         e.first = (i == 0);
         e.last  = (i == len - 1);
         sbq.push_back(e);
      end
      cfg_count = (LG+1)'(n);
      for (int i = 0; i < n; i++) begin
         if (i == glitch_at) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sof = 1'b1; in_sample = 12'h5A5; coef_we = 1'b0;
         end
         @(posedge clk); #1;
         in_valid = 1'b1; in_sof = (i == 0); in_sample = 12'(smp[i]);
         coef_we = (i == poke_at);
         coef_addr = LG'(5); coef_re = 16'sh1111; coef_im = -16'sh2222;
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_sof = 1'b0; coef_we = 1'b0;
   endtask

   task automatic wait_drain(string req);
      int t = 0;
      while (sbq.size() > 0 && t < 20000) begin
         @(negedge clk); t++;
      end
      check(req, "points left undelivered", sbq.size(), 0);
      repeat (3) @(negedge clk);
      check("R4", "valid low after frame", int'(out_valid), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ovf0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R9", "out_valid in reset", int'(out_valid), 0);
      check("R9", "overflow in reset", int'(overflow), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R9", "out_valid after reset", int'(out_valid), 0);

      // R10: samples without a start marker while idle are ignored
      @(posedge clk); #1; in_valid = 1'b1; in_sof = 1'b0; in_sample = 12'sd100; cfg_count = 13'd1;
      repeat (3) @(posedge clk);
      #1 in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check("R10", "no output from unframed samples", int'(out_valid), 0);

      // R1 R2 R3 R5: 12 valid samples padded to 16
      load_coefs(12, 1); fill_samples(12, 1);
      run_frame(12, -1, -1); wait_drain("R1");

      // R1 R7: power-of-two count, no padding, ready toggling
      ready_mode = 1;
      load_coefs(8, 2); fill_samples(8, 2);
      run_frame(8, -1, -1); wait_drain("R1");

      // R2: saturation and rounding extremes; 3 samples padded to 4
      write_coef(0, -32768, -32768);   // -2048 * -1.0 -> 2047 both parts
      write_coef(1, 32767, -32768);
      write_coef(2, 32767, 1);
      smp[0] = -2048; smp[1] = 2047; smp[2] = -2048;
      run_frame(3, -1, -1); wait_drain("R2");

      // R6: coefficient write during capture ignored now and later
      ready_mode = 0;
      load_coefs(12, 3); fill_samples(12, 3);
      run_frame(12, -1, 4); wait_drain("R6");
      run_frame(12, -1, -1); wait_drain("R6");

      // R8: stray start marker during capture
      ovf0 = ovf_seen;
      fill_samples(12, 4);
      run_frame(12, 6, -1); wait_drain("R8");
      check("R8", "overflow pulses during capture", ovf_seen - ovf0, 1);

      // R8 R7: start marker during a stalled emission
      ready_mode = 2;
      ovf0 = ovf_seen;
      fill_samples(12, 5);
      run_frame(12, -1, -1);
      repeat (4) @(posedge clk);
      #1; in_valid = 1'b1; in_sof = 1'b1; in_sample = 12'sd7;
      @(posedge clk); #1; in_valid = 1'b0; in_sof = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", "overflow pulses during emission", ovf_seen - ovf0, 1);
      check("R7", "stalled point still offered", int'(out_valid), 1);
      ready_mode = 0;
      wait_drain("R8");

      // R1: single-sample record gives a one-point frame
      fill_samples(1, 6);
      run_frame(1, -1, -1); wait_drain("R1");

      // R1: 1352 valid samples padded to 2048
      ready_mode = 1;
      load_coefs(1352, 5); fill_samples(1352, 7);
      run_frame(1352, -1, -1); wait_drain("R1");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule